// File: doc/BRIEF.md
# Repartitionable Lookup-Table Memory

This block holds two 16-entry, one-bit-wide truth-table stores, F and G, and lets them serve as writable memory in one of four run-time layouts. The stores can act as two separate 16x1 RAMs. These two RAMs can use their own addresses or share one address. The stores can also be joined into a single 32x1 RAM, or split so that F stays a 16x1 RAM while G acts as a fixed logic table.

The memory controls are a clock enable, a write enable and two data bits (`din0`, `din1`). The fifth variable `hsel` serves two purposes. It is the upper address bit of the 32x1 layout, and it is the select input of the function mux that drives `h_out`.

Reads are combinational from the stores. A write lands at the rising clock edge. The stored bits are the same bits the logic outputs read, so a write changes the combinational result directly. Contents are kept when the layout changes.

Top module: `lutram_modes`

## Requirements
- R1: While `rst_n` is low, and after its release with no write, every entry of both stores reads 0.
- R2: A store entry changes only at a rising `clk` edge where `mem_en` and `mem_we` are both 1. With either signal at 0, nothing is written.
- R3: `mode`=0 (two RAMs, separate addresses): `din0` is written to F at `f_addr` and `din1` is written to G at `g_addr`. `f_out` reads F[`f_addr`] and `g_out` reads G[`g_addr`].
- R4: `mode`=1 (two RAMs, shared address): G is read and written at `f_addr`, and `g_addr` is ignored. F behaves as in R3.
- R5: `mode`=2 (one 32x1 RAM, address {`hsel`,`f_addr`}): `hsel`=0 selects F and `hsel`=1 selects G, at `f_addr`. Only the selected store takes `din0`, and `din1` is ignored. `h_out` returns the addressed bit. `f_out` reads F[`f_addr`] and `g_out` reads G[`f_addr`].
- R6: `mode`=3 (RAM plus function): F is written with `din0` at `f_addr`, and G is never written. `g_out` reads G[`g_addr`].
- R7: In every mode, `h_out` equals `g_out` when `hsel`=1 and `f_out` when `hsel`=0.
- R8: During a write cycle, the outputs show the old contents until the clock edge.
- R9: Contents of both stores are kept across changes of `mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears both stores |
| mode | input | 2 | Layout: 0 dual separate, 1 dual shared, 2 wide 32x1, 3 RAM plus function |
| f_addr | input | AW | Address for F; also the low address bits in modes 1 and 2 |
| g_addr | input | AW | Address for G in modes 0 and 3 |
| hsel | input | 1 | Fifth variable: store select in mode 2 and function-mux select |
| mem_en | input | 1 | Clock enable for writes |
| mem_we | input | 1 | Write enable |
| din0 | input | 1 | Write data for F, or for the selected store in mode 2 |
| din1 | input | 1 | Write data for G in modes 0 and 1 |
| f_out | output | 1 | Contents of F at its read address |
| g_out | output | 1 | Contents of G at its read address |
| h_out | output | 1 | Function-mux output, selected by `hsel` |

## Verification
A write steered to the wrong store, the wrong address or the wrong data bit shows as a wrong bit on `f_out`, `g_out` or `h_out`. It appears as soon as that entry is addressed after the edge, which is within the same step for the entry just written. The bench keeps a model of both stores. After every step it rereads the entry it addressed, and it sweeps all entries after each layout's writes, so a corrupted bit elsewhere appears within one sweep. Stale-read faults appear in the sample taken before the edge of a write cycle.

// File: rtl/lutram_pkg.sv
package lutram_pkg;
    typedef enum logic [1:0] {
        MODE_DUAL_SEP = 2'd0,
        MODE_DUAL_SHR = 2'd1,
        MODE_WIDE     = 2'd2,
        MODE_RAM_FN   = 2'd3
    } lut_mode_e;

    localparam int unsigned NUM_STORES = 2;
    localparam int unsigned STORE_F    = 0;
    localparam int unsigned STORE_G    = 1;
endpackage

// File: rtl/lut_store.sv
module lut_store #(
    parameter int unsigned AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_data
);
    localparam int unsigned DEPTH = 1 << AW;

    typedef struct packed {
        logic [DEPTH-1:0] bits;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.bits[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read is combinational from the registered table
    assign rd_data = st_q.bits[rd_addr];
endmodule

// File: rtl/lut_ctrl.sv
module lut_ctrl
    import lutram_pkg::*;
#(
    parameter int unsigned AW = 4
) (
    input  lut_mode_e     mode,
    input  logic          mem_en,
    input  logic          mem_we,
    input  logic          hsel,
    input  logic          din0,
    input  logic          din1,
    input  logic [AW-1:0] addr_f,
    input  logic [AW-1:0] addr_g,
    output logic          f_wr,
    output logic          f_wd,
    output logic          g_wr,
    output logic          g_wd,
    output logic [AW-1:0] g_ra
);
    logic wr_ok;

    always_comb begin
        wr_ok = mem_en & mem_we;
        f_wr  = 1'b0;
        g_wr  = 1'b0;
        f_wd  = din0;
        g_wd  = din1;
        g_ra  = addr_g;
        unique case (mode)
            MODE_DUAL_SEP: begin
                f_wr = wr_ok;
                g_wr = wr_ok;
            end
            MODE_DUAL_SHR: begin
                f_wr = wr_ok;
                g_wr = wr_ok;
                g_ra = addr_f;
            end
            MODE_WIDE: begin
                // hsel is the fifth address bit: picks the half
                f_wr = wr_ok & ~hsel;
                g_wr = wr_ok & hsel;
                g_wd = din0;
                g_ra = addr_f;
            end
            MODE_RAM_FN: begin
                f_wr = wr_ok;
            end
            default: begin
                f_wr = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lutram_modes.sv
module lutram_modes
    import lutram_pkg::*;
#(
    parameter int unsigned AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] f_addr,
    input  logic [AW-1:0] g_addr,
    input  logic          hsel,
    input  logic          mem_en,
    input  logic          mem_we,
    input  logic          din0,
    input  logic          din1,
    output logic          f_out,
    output logic          g_out,
    output logic          h_out
);
    logic          wr   [NUM_STORES];
    logic          wd   [NUM_STORES];
    logic [AW-1:0] addr [NUM_STORES];
    logic          rd   [NUM_STORES];

    lut_ctrl #(.AW(AW)) u_ctrl (
        .mode   (lut_mode_e'(mode)),
        .mem_en (mem_en),
        .mem_we (mem_we),
        .hsel   (hsel),
        .din0   (din0),
        .din1   (din1),
        .addr_f (f_addr),
        .addr_g (g_addr),
        .f_wr   (wr[STORE_F]),
        .f_wd   (wd[STORE_F]),
        .g_wr   (wr[STORE_G]),
        .g_wd   (wd[STORE_G]),
        .g_ra   (addr[STORE_G])
    );

    assign addr[STORE_F] = f_addr;

    for (genvar i = 0; i < NUM_STORES; i++) begin : g_store
        lut_store #(.AW(AW)) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr[i]),
            .wr_addr (addr[i]),
            .wr_data (wd[i]),
            .rd_addr (addr[i]),
            .rd_data (rd[i])
        );
    end

    assign f_out = rd[STORE_F];
    assign g_out = rd[STORE_G];
    assign h_out = hsel ? rd[STORE_G] : rd[STORE_F];
endmodule

// File: rtl/lutram_modes_chk.sv
module lutram_modes_chk #(
    parameter int unsigned AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic [AW-1:0] f_addr,
    input logic [AW-1:0] g_addr,
    input logic          hsel,
    input logic          mem_en,
    input logic          mem_we,
    input logic          din0,
    input logic          din1,
    input logic          f_out,
    input logic          g_out,
    input logic          h_out
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!(mem_en && mem_we)) && $stable(f_addr) && $stable(g_addr)
            && $stable(mode) && $stable(hsel))
        |-> ($stable(f_out) && $stable(g_out) && $stable(h_out)));

    p_sep_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd0) && mem_en && mem_we)
            ##1 ($stable(f_addr) && $stable(g_addr) && $stable(mode))
        |-> (f_out == $past(din0) && g_out == $past(din1)));

    p_shr_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd1) && mem_en && mem_we)
            ##1 ($stable(f_addr) && $stable(mode))
        |-> (f_out == $past(din0) && g_out == $past(din1)));

    p_wide_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd2) && mem_en && mem_we)
            ##1 ($stable(f_addr) && $stable(hsel) && $stable(mode))
        |-> (h_out == $past(din0)));

    p_fn_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd3) && ($past(mode) == 2'd3) && $stable(g_addr))
        |-> $stable(g_out));
endmodule

bind lutram_modes lutram_modes_chk #(.AW(AW)) u_chk (.*);

// File: tb/lutram_modes_test.sv
module lutram_modes_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [3:0] f_addr = '0;
    logic [3:0] g_addr = '0;
    logic       hsel = 1'b0;
    logic       mem_en = 1'b0;
    logic       mem_we = 1'b0;
    logic       din0 = 1'b0;
    logic       din1 = 1'b0;
    logic       f_out, g_out, h_out;

    logic fm [16];
    logic gm [16];
    int   n_run  = 0;
    int   n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lutram_modes #(.AW(4)) uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .f_addr(f_addr), .g_addr(g_addr),
        .hsel(hsel), .mem_en(mem_en), .mem_we(mem_we), .din0(din0), .din1(din1),
        .f_out(f_out), .g_out(g_out), .h_out(h_out)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        logic [3:0] gra;
        logic ef, eg;
        gra = (mode == 2'd0 || mode == 2'd3) ? g_addr : f_addr;
        ef  = fm[f_addr];
        eg  = gm[gra];
        chk({tag, " f_out"}, f_out, ef);
        chk({tag, " g_out"}, g_out, eg);
        chk({tag, " h_out R7"}, h_out, hsel ? eg : ef);
    endtask

    // one clock step: drive, check old contents, clock, update model, check
    task automatic step(input logic [1:0] m, input logic [3:0] fa, input logic [3:0] ga,
                        input logic hs, input logic en, input logic we,
                        input logic d0, input logic d1, input string tag);
        @(negedge clk);
        mode = m; f_addr = fa; g_addr = ga; hsel = hs;
        mem_en = en; mem_we = we; din0 = d0; din1 = d1;
        #1;
        check_outs("R8 pre-edge");
        @(posedge clk);
        if (en && we) begin
            case (m)
                2'd0: begin fm[fa] = d0; gm[ga] = d1; end
                2'd1: begin fm[fa] = d0; gm[fa] = d1; end
                2'd2: if (hs) gm[fa] = d0; else fm[fa] = d0;
                default: fm[fa] = d0;
            endcase
        end
        #(CLK_PERIOD/4);
        check_outs(tag);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 16; i++) begin fm[i] = 1'b0; gm[i] = 1'b0; end
        #3;
        chk("R1 in reset f_out", f_out, 1'b0);
        chk("R1 in reset g_out", g_out, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 16; i++) step(2'd0, 4'(i), 4'(15 - i), i[0], 1'b0, 1'b0, 1'b0, 1'b0, "R1 sweep");
    endtask

    task automatic t_dual_sep();
        for (int i = 0; i < 16; i++)
            step(2'd0, 4'(i), 4'(15 - i), 1'b0, 1'b1, 1'b1, i[0], ~i[1], "R3 write");
        for (int i = 0; i < 16; i++)
            step(2'd0, 4'(i), 4'((i * 5) % 16), i[1], 1'b0, 1'b0, 1'b0, 1'b0, "R3 read");
    endtask

    task automatic t_dual_shr();
        for (int i = 0; i < 16; i += 3)
            step(2'd1, 4'(i), 4'(i + 7), 1'b1, 1'b1, 1'b1, ~i[0], i[2], "R4 write");
        for (int i = 0; i < 16; i++)
            step(2'd1, 4'(i), 4'(15 - i), i[0], 1'b0, 1'b0, 1'b0, 1'b0, "R4 read");
    endtask

    task automatic t_wide();
        for (int i = 0; i < 32; i++)
            step(2'd2, 4'(i), 4'(i + 3), i[4], 1'b1, 1'b1, i[0] ^ i[2] ^ i[4], ~(i[0] ^ i[2] ^ i[4]), "R5 write");
        for (int i = 0; i < 32; i++)
            step(2'd2, 4'(i), 4'(0), i[4], 1'b0, 1'b0, 1'b0, 1'b0, "R5 read");
    endtask

    task automatic t_fn();
        for (int i = 0; i < 16; i++)
            step(2'd3, 4'(i), 4'(i), 1'b1, 1'b1, 1'b1, ~i[1], ~gm[i], "R6 write");
        for (int i = 0; i < 16; i++)
            step(2'd3, 4'(15 - i), 4'(i), i[0], 1'b0, 1'b0, 1'b0, 1'b0, "R6 read");
    endtask

    task automatic t_gate();
        step(2'd0, 4'd5, 4'd9, 1'b0, 1'b1, 1'b0, ~fm[5], ~gm[9], "R2 we low");
        step(2'd0, 4'd5, 4'd9, 1'b1, 1'b0, 1'b1, ~fm[5], ~gm[9], "R2 en low");
        step(2'd2, 4'd6, 4'd0, 1'b1, 1'b0, 1'b1, ~gm[6], 1'b0, "R2 wide en low");
        step(2'd0, 4'd5, 4'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 readback");
    endtask

    task automatic t_rdw();
        for (int k = 0; k < 4; k++)
            step(2'd0, 4'd12, 4'd3, k[0], 1'b1, 1'b1, ~fm[12], ~gm[3], "R8 toggle");
    endtask

    task automatic t_persist();
        for (int i = 0; i < 16; i++)
            step(2'd0, 4'(i), 4'(i), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 mode change");
        for (int i = 0; i < 16; i++)
            step(2'd2, 4'(i), 4'(i), i[0], 1'b0, 1'b0, 1'b0, 1'b0, "R9 back to wide");
    endtask

    initial begin
        t_reset();
        t_dual_sep();
        t_dual_shr();
        t_wide();
        t_fn();
        t_gate();
        t_rdw();
        t_persist();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule